// File: doc/BRIEF.md
# Infrared serial pulse codec

This block sits between a UART-style serial port and an infrared transceiver. Its transmit half turns the port's NRZ output line into short light pulses: a 0 bit becomes a high pulse three sixteenths of a bit long, and a 1 bit sends nothing. Its receive half watches the photodetector line, which rests high and dips low for each pulse, and stretches every dip back into a low level one full bit long. The UART receiver then sees ordinary NRZ data.

Both halves are timed by a one-clock-wide tick at sixteen times the bit rate, supplied from outside. At the top rate of 115.2 kbit/s this is a 1.8432 MHz tick. An enable input selects infrared operation. A second input reports that the port also has a setting active that cannot be combined with infrared operation: clock output, smartcard, single-wire half duplex, LIN, or a non-standard stop length. When that input is set, the block passes both lines straight through. The serial lines carry no valid/ready handshake, so there is no back-pressure. Every pin is a plain level that is sampled on each clock.

Top module: `irda_codec`

## Requirements
- R1: While reset is asserted, `tx_ir` is 0 whatever the other inputs are. After reset, with infrared mode active and `rx_ir` high, `rx_nrz` is 1 and `tx_ir` is 0.
- R2: Infrared mode is active when `ir_en`=1 and `mode_clash`=0. Entering this mode starts a bit at phase 0. The next tick edge is phase 0 of a bit, and every 16 tick edges form one bit. If `tx_nrz`=0 at the phase-0 tick edge, `tx_ir` goes to 1 at that edge. It returns to 0 at the phase-3 tick edge, so the pulse lasts 3 ticks.
- R3: If `tx_nrz`=1 at the phase-0 tick edge, `tx_ir` stays 0 for the whole bit. Changes of `tx_nrz` at phases 1 to 15 have no effect on `tx_ir`.
- R4: `rx_ir` passes through a 2-flop synchronizer and is then sampled at every tick edge. If the sample is 0 and the previous tick sample was 1, `rx_nrz` goes to 0 at that edge. It returns to 1 after 16 further tick edges.
- R5: A new falling sample while `rx_nrz` is still low restarts the 16-tick count. Back-to-back 0 bits therefore give one unbroken low level.
- R6: A low pulse on `rx_ir` that ends before any tick edge samples it leaves `rx_nrz` at 1.
- R7: With `ir_en`=0, `tx_ir` is 0 and `rx_nrz` is 1 regardless of `tx_nrz` and `rx_ir`.
- R8: With `ir_en`=1 and `mode_clash`=1, `tx_ir` follows `tx_nrz` and `rx_nrz` follows `rx_ir` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_en | input | 1 | Selects infrared operation |
| mode_clash | input | 1 | An incompatible port setting is active; forces pass-through |
| tick16 | input | 1 | One-clock strobe at 16x the bit rate |
| tx_nrz | input | 1 | NRZ transmit line from the UART |
| tx_ir | output | 1 | Pulse output to the LED driver, idles 0 |
| rx_ir | input | 1 | Photodetector line, idles 1 |
| rx_nrz | output | 1 | Recovered NRZ line to the UART, idles 1 |

## Verification
The bench checks the pulse length tick by tick. A design that held the pulse for 2 or 4 ticks, or that aligned it to the wrong phase, shows a mismatch at the third or fourth tick of a 0 bit. Flipping `tx_nrz` in the middle of a bit catches an encoder that samples continuously rather than once per bit. On the receive side, 0 bits spaced 16 ticks apart and 8 ticks apart check the restart. A decoder that did not restart the count would show a high glitch, or release the line too early. A one-clock dip placed between ticks catches a decoder that reacts to raw edges. The off and pass-through modes are checked at the pins with both lines driven to their active levels.

// File: rtl/irda_codec_pkg.sv
package irda_codec_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_IR     = 2'd1,
    MODE_BYPASS = 2'd2
  } ir_mode_e;
endpackage

// File: rtl/irda_mode_sel.sv
module irda_mode_sel
  import irda_codec_pkg::*;
(
  input  logic     ir_en,
  input  logic     mode_clash,
  output ir_mode_e mode,
  output logic     ir_active
);
  always_comb begin
    if (!ir_en)          mode = MODE_OFF;
    else if (mode_clash) mode = MODE_BYPASS;
    else                 mode = MODE_IR;
  end

  assign ir_active = (mode == MODE_IR);
endmodule

// File: rtl/irda_sir_enc.sv
module irda_sir_enc #(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic nrz,
  output logic pulse
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(PULSE_TICKS);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pulse <= 1'b0;
    end else if (!active) begin
      phase <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (phase == '0)
        pulse <= ~nrz;
      else if (phase == PH_END)
        pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/irda_sir_dec.sv
module irda_sir_dec #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic line,
  output logic nrz
);
  localparam int CW = $clog2(OVS + 1);
  localparam logic [CW-1:0] HOLD = CW'(OVS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   tick_smp;
  logic                   fall;
  logic [CW-1:0]          hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line};
  end

  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick_smp <= 1'b1;
    else if (tick) tick_smp <= line_s;
  end

  assign fall = tick && tick_smp && !line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (!active)
      hold_cnt <= '0;
    else if (fall)
      hold_cnt <= HOLD;
    else if (tick && hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  assign nrz = (hold_cnt == '0);
endmodule

// File: rtl/irda_codec.sv
module irda_codec
  import irda_codec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_en,
  input  logic mode_clash,
  input  logic tick16,
  input  logic tx_nrz,
  output logic tx_ir,
  input  logic rx_ir,
  output logic rx_nrz
);
  ir_mode_e mode;
  logic     ir_active;
  logic     enc_pulse;
  logic     dec_nrz;

  irda_mode_sel u_mode (
    .ir_en      (ir_en),
    .mode_clash (mode_clash),
    .mode       (mode),
    .ir_active  (ir_active)
  );

  irda_sir_enc #(.OVS(OVS), .PULSE_TICKS(PULSE_TICKS)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (ir_active),
    .tick   (tick16),
    .nrz    (tx_nrz),
    .pulse  (enc_pulse)
  );

  irda_sir_dec #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (ir_active),
    .tick   (tick16),
    .line   (rx_ir),
    .nrz    (dec_nrz)
  );

  always_comb begin
    unique case (mode)
      MODE_IR:     tx_ir = enc_pulse;
      MODE_BYPASS: tx_ir = tx_nrz;
      default:     tx_ir = 1'b0;
    endcase
    if (!rst_n) tx_ir = 1'b0;
  end

  always_comb begin
    unique case (mode)
      MODE_IR:     rx_nrz = dec_nrz;
      MODE_BYPASS: rx_nrz = rx_ir;
      default:     rx_nrz = 1'b1;
    endcase
  end
endmodule

// File: rtl/irda_codec_chk.sv
module irda_codec_chk #(
  parameter int PULSE_TICKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ir_en,
  input logic mode_clash,
  input logic tick16,
  input logic tx_nrz,
  input logic tx_ir,
  input logic rx_ir,
  input logic rx_nrz
);
  logic       ir_on;
  logic [7:0] hi_ticks;

  assign ir_on = ir_en && !mode_clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_ticks <= '0;
    else if (!(ir_on && tx_ir)) hi_ticks <= '0;
    else if (tick16 && hi_ticks != 8'hff) hi_ticks <= hi_ticks + 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (tx_ir == 1'b0);
    end
  end

  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_on && tx_ir) |-> (hi_ticks < 8'(PULSE_TICKS)));

  p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_on && $past(ir_on) && $rose(tx_ir)) |-> ($past(tick16) && !$past(tx_nrz)));

  p_rx_fall_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_on && $past(ir_on) && $fell(rx_nrz)) |-> $past(tick16));

  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en |-> (!tx_ir && rx_nrz));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && mode_clash) |-> (tx_ir == tx_nrz && rx_nrz == rx_ir));
endmodule

bind irda_codec irda_codec_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ir_en      (ir_en),
  .mode_clash (mode_clash),
  .tick16     (tick16),
  .tx_nrz     (tx_nrz),
  .tx_ir      (tx_ir),
  .rx_ir      (rx_ir),
  .rx_nrz     (rx_nrz)
);

// File: tb/irda_codec_bench.sv
module irda_codec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_en = 1'b0;
  logic mode_clash = 1'b0;
  logic tick16 = 1'b0;
  logic tx_nrz = 1'b1;
  logic rx_ir = 1'b1;
  logic tx_ir;
  logic rx_nrz;

  int total = 0;
  int bad = 0;

  irda_codec u_irda_codec (
    .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .mode_clash(mode_clash),
    .tick16(tick16), .tx_nrz(tx_nrz), .tx_ir(tx_ir),
    .rx_ir(rx_ir), .rx_nrz(rx_nrz)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk);
      #1 tick16 = 1'b1;
      @(posedge clk);
      #1 tick16 = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick16);
  endtask

  task automatic enter_ir();
    @(negedge clk); ir_en = 1'b0; mode_clash = 1'b0;
    repeat (2) @(negedge clk);
    while (tick16) @(negedge clk);
    ir_en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ir_en = 1'b1; mode_clash = 1'b1; tx_nrz = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_ir, 1'b0, "R1 tx_ir held low in reset");
    rst_n = 1'b1; mode_clash = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_nrz, 1'b1, "R1 rx_nrz idle after reset");
    chk(tx_ir, 1'b0, "R1 tx_ir idle after reset");
  endtask

  task automatic t_encode(input logic [7:0] bits);
    enter_ir();
    for (int b = 0; b < 8; b++) begin
      tx_nrz = bits[b];
      for (int k = 0; k < 16; k++) begin
        wait_tick();
        @(negedge clk);
        chk(tx_ir, (bits[b] == 1'b0) && (k < 3),
            bits[b] ? "R3 no pulse for 1 bit" : "R2 pulse for 0 bit");
        if (k == 5) tx_nrz = ~bits[b];
      end
    end
    tx_nrz = 1'b1;
  endtask

  task automatic t_decode(input int s0, input int s1, input string tag);
    int last = (s1 > s0) ? s1 : s0;
    for (int k = 0; k < last + 20; k++) begin
      logic lo_in;
      logic exp;
      wait_tick();
      lo_in = (k >= s0 && k < s0 + 3) || (s1 >= 0 && k >= s1 && k < s1 + 3);
      rx_ir = ~lo_in;
      exp = !((k >= s0 + 1 && k <= s0 + 16) ||
              (s1 >= 0 && k >= s1 + 1 && k <= s1 + 16));
      @(negedge clk);
      chk(rx_nrz, exp, tag);
    end
    rx_ir = 1'b1;
  endtask

  task automatic t_glitch();
    wait_tick();
    @(negedge clk); rx_ir = 1'b0;
    @(negedge clk); rx_ir = 1'b1;
    for (int k = 0; k < 20; k++) begin
      wait_tick();
      @(negedge clk);
      chk(rx_nrz, 1'b1, "R6 dip between ticks ignored");
    end
  endtask

  task automatic t_off();
    @(negedge clk); ir_en = 1'b0; tx_nrz = 1'b0; rx_ir = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(tx_ir, 1'b0, "R7 tx_ir idle when off");
      chk(rx_nrz, 1'b1, "R7 rx_nrz high when off");
    end
    tx_nrz = 1'b1; rx_ir = 1'b1;
  endtask

  task automatic t_bypass();
    @(negedge clk); ir_en = 1'b1; mode_clash = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tx_nrz = i[0]; rx_ir = i[1];
      #1;
      chk(tx_ir, i[0], "R8 tx pass-through");
      chk(rx_nrz, i[1], "R8 rx pass-through");
      @(negedge clk);
    end
    mode_clash = 1'b0; tx_nrz = 1'b1; rx_ir = 1'b1;
  endtask

  initial begin
    t_reset();
    t_encode(8'b0110_1100);
    t_encode(8'b1010_0001);
    enter_ir();
    repeat (8) @(negedge clk);
    t_decode(0, -1, "R4 single pulse stretched");
    t_decode(0, 16, "R5 back-to-back zeros");
    t_decode(0, 8, "R5 restart inside window");
    t_glitch();
    t_off();
    t_bypass();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule